// File: doc/BRIEF.md
# Zero-Overhead Loop Repeat Controller

This block sequences hardware loops for a compact DSP-style fetch unit. Software loads a loop-start address, a loop-end address and a 12-bit repeat count. While the count is non-zero, a fetch at the end address sends the program counter back to the start address and lowers the count by one. When the count is one at the end address, execution falls through and the count drops to zero. Loop-back costs no extra instruction.

The block also enforces the usage rules for loops. The count can be set from an 8-bit immediate, which is zero-extended, or from a full 12-bit register operand. Setting the count before both addresses are loaded is flagged as a sequencing error and the count is left as it was. Placing the set-count instruction directly in front of the loop start is flagged as a spacing violation. A body shorter than four instructions must not hold any instruction that changes control flow or loop state. Such an instruction raises an illegal-instruction exception and supplies the PC to save. Longer bodies are allowed, and their loop-back asks the fetch unit for a stall. The block does not insert stalls and does not vector the exception.

All outputs are combinational from the current fetch inputs and the registered loop state. Register loads take effect at the next clock edge.

Top module: `zol_sequencer`

## Requirements
- R1: After reset the count is 0, both addresses count as unloaded, and with a plain fetch `nextPc` equals `fetchPc + 1`. No exception and no stall are raised.
- R2: With `setCntImm`=1 the count loads `cntImm` zero-extended and `cntReg` is ignored. With `setCntImm`=0 the count loads all 12 bits of `cntReg` and `cntImm` is ignored.
- R3: A fetch at the end address with count > 1 gives `nextPc` = start address and lowers the count by one. A count of N therefore produces N-1 loop-backs.
- R4: A fetch at the end address with count = 1 gives `nextPc` = end + 1 and clears the count, so the next fetch of the end address falls through.
- R5: `seqErr` is 1 in a cycle with `setCntEn`=1 while the start or end address has not been loaded since reset. In that case the count is not written.
- R6: `spacingErr` is 1 when `setCntEn`=1 and `fetchPc + 1` equals the loaded start address. The count is still written.
- R7: Instruction class codes are 0 plain, 1 branch/call/return, 2 loop-register or set-count write, 3 status or loop-address load, 4 trap; any non-zero code is forbidden in short loops. With count ≠ 0 and end − start + 1 < 4, a fetch inside [start, end] of a non-zero class raises `excValid`. A plain fetch in the body, or a fetch outside it, raises no exception.
- R8: When `excValid` is 1, `excPc` is the start address if the count is 2 or more, and `fetchPc` if the count is 1.
- R9: A forbidden fetch at the end address of a short loop does not loop back (`nextPc` = end + 1) and leaves the count unchanged.
- R10: For a body of four or more instructions, no class raises an exception. `stallReq` is 1 exactly on loop-back fetches of such bodies and 0 on every loop-back of a short body.
- R11: With count 0, a fetch at the end address falls through and no class raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldStartEn | input | 1 | Load `ldAddr` into the loop-start register |
| ldEndEn | input | 1 | Load `ldAddr` into the loop-end register |
| ldAddr | input | 16 | Address operand for the start/end loads |
| setCntEn | input | 1 | Set-count instruction, presented with its own address on `fetchPc` |
| setCntImm | input | 1 | 1: immediate form, 0: register form |
| cntImm | input | 8 | Immediate count operand |
| cntReg | input | 12 | Register count operand |
| fetchValid | input | 1 | `fetchPc`/`instClass` describe a fetched instruction |
| fetchPc | input | 16 | Current fetch address |
| instClass | input | 3 | Decoded instruction class (codes in R7) |
| nextPc | output | 16 | Next fetch address |
| excValid | output | 1 | Illegal-instruction exception in a short loop |
| excPc | output | 16 | PC to save for the exception |
| seqErr | output | 1 | Count set before both addresses were loaded |
| spacingErr | output | 1 | Set-count placed directly before the loop start |
| stallReq | output | 1 | Loop-back of a long body requests pipeline stalls |

## Verification
The functions that can meet in one cycle are the loop-back at the end address and the short-loop exception: a forbidden instruction placed at the last body address is eligible for both. The bench sweeps every class at every offset of bodies of one to five instructions and counts of one to three. For the colliding case it checks that the exception is raised with the count-dependent saved PC, that the PC falls through, and, on a following plain fetch of the end address, that the loop-back still happens for the unchanged count. Loop-back and stall behaviour are checked against a walk of the loop computed in the bench for lengths one to six and counts one to five, and against long runs with 8-bit and 12-bit count loads.

// File: rtl/zol_seq_pkg.sv
package zol_seq_pkg;

  typedef enum logic [2:0] {
    CLS_PLAIN   = 3'd0,
    CLS_FLOW    = 3'd1,
    CLS_LOOPCTL = 3'd2,
    CLS_SYSLOAD = 3'd3,
    CLS_TRAP    = 3'd4
  } instClass_e;

  // Decisions handed from control to datapath each cycle
  typedef struct packed {
    logic cntLoad;     // write count from set-count operand
    logic cntDec;      // loop-back: count - 1
    logic cntClear;    // last pass: count -> 0
    logic takeBack;    // nextPc = start address
    logic excRaise;    // short-loop illegal instruction
    logic excAtStart;  // saved PC is the start address
  } ctrlStrobe_t;

endpackage

// File: rtl/zol_seq_dp.sv
module zol_seq_dp
  import zol_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldStartEn,
  input  logic              ldEndEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              setCntImm,
  input  logic [IMM_W-1:0]  cntImm,
  input  logic [CNT_W-1:0]  cntReg,
  input  logic [ADDR_W-1:0] fetchPc,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] endAddr,
  output logic [CNT_W-1:0]  cnt,
  output logic              addrsReady,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] excPc
);

  localparam int PAD_W = CNT_W - IMM_W;

  logic [ADDR_W-1:0] startQ, endQ;
  logic [CNT_W-1:0]  cntQ, cntLoadVal;
  logic              startSetQ, endSetQ;

  assign cntLoadVal = setCntImm ? {{PAD_W{1'b0}}, cntImm} : cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ    <= '0;
      endQ      <= '0;
      startSetQ <= 1'b0;
      endSetQ   <= 1'b0;
    end else begin
      if (ldStartEn) begin
        startQ    <= ldAddr;
        startSetQ <= 1'b1;
      end
      if (ldEndEn) begin
        endQ    <= ldAddr;
        endSetQ <= 1'b1;
      end
    end
  end

  // Count: a new load wins over the loop-end update
  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobe.cntLoad)  cntQ <= cntLoadVal;
    else if (strobe.cntDec)   cntQ <= cntQ - CNT_W'(1);
    else if (strobe.cntClear) cntQ <= '0;
  end

  assign startAddr  = startQ;
  assign endAddr    = endQ;
  assign cnt        = cntQ;
  assign addrsReady = startSetQ && endSetQ;
  assign nextPc     = strobe.takeBack ? startQ : fetchPc + ADDR_W'(1);
  assign excPc      = strobe.excAtStart ? startQ : fetchPc;

  p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntDec && !strobe.cntLoad) |=> cntQ == $past(cntQ) - CNT_W'(1));

  p_cnt_exit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntClear && !strobe.cntLoad) |=> cntQ == '0);

  p_exc_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.excRaise && !strobe.cntLoad) |=> cntQ == $past(cntQ));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntDec |-> cntQ > CNT_W'(1));

endmodule

// File: rtl/zol_seq_ctrl.sv
module zol_seq_ctrl
  import zol_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 12,
  parameter int SHORT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [2:0]        instClass,
  input  logic              setCntEn,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              addrsReady,
  output ctrlStrobe_t       strobe,
  output logic              excValid,
  output logic              seqErr,
  output logic              spacingErr,
  output logic              stallReq
);

  localparam logic [ADDR_W-1:0] SPAN_LIM = ADDR_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic              loopOn, rangeOk, isShort, inBody, forbidden;
  logic              illegal, atEnd;
  logic [ADDR_W-1:0] span;

  assign loopOn    = (cnt != '0);
  assign rangeOk   = (endAddr >= startAddr);
  assign span      = endAddr - startAddr;
  assign isShort   = rangeOk && (span < SPAN_LIM);
  assign inBody    = fetchValid && loopOn && rangeOk &&
                     (fetchPc >= startAddr) && (fetchPc <= endAddr);
  assign forbidden = (instClass != CLS_PLAIN);
  assign illegal   = inBody && isShort && forbidden;
  assign atEnd     = fetchValid && loopOn && rangeOk &&
                     (fetchPc == endAddr) && !illegal;

  always_comb begin
    strobe            = '0;
    strobe.cntLoad    = setCntEn && addrsReady;
    strobe.takeBack   = atEnd && (cnt > CNT_ONE);
    strobe.cntDec     = atEnd && (cnt > CNT_ONE);
    strobe.cntClear   = atEnd && (cnt == CNT_ONE);
    strobe.excRaise   = illegal;
    strobe.excAtStart = illegal && (cnt > CNT_ONE);
  end

  assign excValid   = illegal;
  assign seqErr     = setCntEn && !addrsReady;
  assign spacingErr = setCntEn && ((fetchPc + ADDR_W'(1)) == startAddr);
  assign stallReq   = strobe.takeBack && !isShort;

  p_exc_in_body_r7: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (fetchPc >= startAddr) && (fetchPc <= endAddr) && fetchValid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> !excValid && !stallReq && !strobe.takeBack);

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
  import zol_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 12,
  parameter int IMM_W     = 8,
  parameter int SHORT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldStartEn,
  input  logic              ldEndEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              setCntEn,
  input  logic              setCntImm,
  input  logic [IMM_W-1:0]  cntImm,
  input  logic [CNT_W-1:0]  cntReg,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchPc,
  input  logic [2:0]        instClass,
  output logic [ADDR_W-1:0] nextPc,
  output logic              excValid,
  output logic [ADDR_W-1:0] excPc,
  output logic              seqErr,
  output logic              spacingErr,
  output logic              stallReq
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] startAddr, endAddr;
  logic [CNT_W-1:0]  cnt;
  logic              addrsReady;

  zol_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .instClass(instClass), .setCntEn(setCntEn), .startAddr(startAddr),
    .endAddr(endAddr), .cnt(cnt), .addrsReady(addrsReady), .strobe(strobe),
    .excValid(excValid), .seqErr(seqErr), .spacingErr(spacingErr),
    .stallReq(stallReq)
  );

  zol_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IMM_W(IMM_W)) i_dp (
    .clk(clk), .rstN(rstN), .ldStartEn(ldStartEn), .ldEndEn(ldEndEn),
    .ldAddr(ldAddr), .setCntImm(setCntImm), .cntImm(cntImm), .cntReg(cntReg),
    .fetchPc(fetchPc), .strobe(strobe), .startAddr(startAddr),
    .endAddr(endAddr), .cnt(cnt), .addrsReady(addrsReady), .nextPc(nextPc),
    .excPc(excPc)
  );

  p_seq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seqErr && !fetchValid) |=> cnt == $past(cnt));

  p_stall_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> nextPc == startAddr);

  p_excpc_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && cnt == CNT_W'(1)) |-> excPc == fetchPc);

endmodule

// File: tb/test_zol_sequencer.sv
module test_zol_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldStartEn = 1'b0, ldEndEn = 1'b0;
  logic [15:0] ldAddr = '0;
  logic        setCntEn = 1'b0, setCntImm = 1'b0;
  logic [7:0]  cntImm = '0;
  logic [11:0] cntReg = '0;
  logic        fetchValid = 1'b0;
  logic [15:0] fetchPc = '0;
  logic [2:0]  instClass = '0;
  logic [15:0] nextPc, excPc;
  logic        excValid, seqErr, spacingErr, stallReq;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] sNext, sExcPc;
  logic        sExc, sStall, sSeq, sSpc;

  always #10 clk = ~clk;

  zol_sequencer i_zol_sequencer (
    .clk(clk), .rstN(rstN), .ldStartEn(ldStartEn), .ldEndEn(ldEndEn),
    .ldAddr(ldAddr), .setCntEn(setCntEn), .setCntImm(setCntImm),
    .cntImm(cntImm), .cntReg(cntReg), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .instClass(instClass), .nextPc(nextPc),
    .excValid(excValid), .excPc(excPc), .seqErr(seqErr),
    .spacingErr(spacingErr), .stallReq(stallReq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic loadAddr(input logic [15:0] s, input logic [15:0] e, input bit doS, input bit doE);
    if (doS) begin
      @(negedge clk); ldStartEn = 1'b1; ldAddr = s;
      @(posedge clk); #1 ldStartEn = 1'b0;
    end
    if (doE) begin
      @(negedge clk); ldEndEn = 1'b1; ldAddr = e;
      @(posedge clk); #1 ldEndEn = 1'b0;
    end
  endtask

  task automatic setCount(input bit imm, input logic [7:0] iv, input logic [11:0] rv, input logic [15:0] pc);
    @(negedge clk);
    setCntEn = 1'b1; setCntImm = imm; cntImm = iv; cntReg = rv;
    fetchPc = pc; fetchValid = 1'b0;
    #2 sSeq = seqErr; sSpc = spacingErr;
    @(posedge clk); #1 setCntEn = 1'b0;
  endtask

  task automatic fetchOne(input logic [15:0] pc, input logic [2:0] cls);
    @(negedge clk);
    fetchValid = 1'b1; fetchPc = pc; instClass = cls;
    #2 sNext = nextPc; sExc = excValid; sExcPc = excPc; sStall = stallReq;
    @(posedge clk); #1 fetchValid = 1'b0; instClass = 3'd0;
  endtask

  // Walk a loop with plain instructions; model computed from R3/R4/R10
  task automatic walk(input logic [15:0] s, input int len, input int c, output int backs);
    logic [15:0] e, pc, expNext;
    int rem, steps;
    bit back;
    e = s + 16'(len - 1); pc = s - 16'd1; rem = c; backs = 0; steps = 0;
    while (pc != e + 16'd2 && steps < 20000) begin
      fetchOne(pc, 3'd0);
      back = (pc == e) && (rem > 1);
      if (back) begin expNext = s; rem--; backs++; end
      else begin
        expNext = pc + 16'd1;
        if (pc == e && rem == 1) rem = 0;
      end
      if (pc == e) check(sNext == expNext, back ? "R3 loop-back" : "R4 loop exit", sNext, expNext);
      else if (sNext != expNext) check(1'b0, "R3 body step", sNext, expNext);
      if (back) check(sStall == (len >= 4), "R10 stall on loop-back", sStall, (len >= 4));
      else if (sStall) check(1'b0, "R10 stall off", sStall, 0);
      if (sExc) check(1'b0, "R7 plain raises nothing", sExc, 0);
      pc = expNext;
      steps++;
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int backs;
    logic [15:0] s, e, pc;
    bit expExc;

    // R1: reset state
    doReset();
    fetchOne(16'h0010, 3'd0);
    check(sNext == 16'h0011, "R1 reset nextPc", sNext, 16'h0011);
    check(!sExc && !sStall, "R1 reset no exc/stall", {sExc, sStall}, 0);
    setCount(1'b1, 8'd3, 12'd0, 16'h0000);
    check(sSeq == 1'b1, "R1 addresses unloaded after reset", sSeq, 1);

    // R11: count 0 disables looping and checks
    loadAddr(16'h0020, 16'h0021, 1, 1);
    fetchOne(16'h0021, 3'd4);
    check(sNext == 16'h0022, "R11 no loop at count 0", sNext, 16'h0022);
    check(sExc == 1'b0, "R11 no exception at count 0", sExc, 0);

    // R5: sequencing error with one address missing; count not written
    doReset();
    loadAddr(16'h0030, 16'h0031, 1, 0);
    setCount(1'b1, 8'd4, 12'd0, 16'h0000);
    check(sSeq == 1'b1, "R5 seqErr with end unloaded", sSeq, 1);
    loadAddr(16'h0030, 16'h0031, 0, 1);
    fetchOne(16'h0031, 3'd0);
    check(sNext == 16'h0032, "R5 count not written", sNext, 16'h0032);
    setCount(1'b1, 8'd2, 12'd0, 16'h0000);
    check(sSeq == 1'b0, "R5 no seqErr once loaded", sSeq, 0);

    // R6: spacing violation
    doReset();
    loadAddr(16'h0050, 16'h0052, 1, 1);
    setCount(1'b1, 8'd2, 12'd0, 16'h004E);
    check(sSpc == 1'b0, "R6 one instruction gap is fine", sSpc, 0);
    setCount(1'b1, 8'd2, 12'd0, 16'h004F);
    check(sSpc == 1'b1, "R6 adjacent set-count flagged", sSpc, 1);
    fetchOne(16'h0052, 3'd0);
    check(sNext == 16'h0050, "R6 count still written", sNext, 16'h0050);

    // R3/R4/R10: sweep lengths 1..6 and counts 1..5
    for (int len = 1; len <= 6; len++) begin
      for (int c = 1; c <= 5; c++) begin
        s = 16'h0100 + 16'(len * 16);
        doReset();
        loadAddr(s, s + 16'(len - 1), 1, 1);
        setCount(1'b1, 8'(c), 12'd0, s - 16'd3);
        walk(s, len, c, backs);
        check(backs == c - 1, "R3 loop-back count", backs, c - 1);
        fetchOne(s + 16'(len - 1), 3'd0);
        check(sNext == s + 16'(len), "R4 count cleared after exit", sNext, s + 16'(len));
      end
    end

    // R2: immediate form zero-extends, register field ignored
    doReset();
    loadAddr(16'h0200, 16'h0200, 1, 1);
    setCount(1'b1, 8'hFF, 12'hFFF, 16'h01F0);
    walk(16'h0200, 1, 255, backs);
    check(backs == 254, "R2 immediate count 255", backs, 254);
    // R2: register form uses 12 bits, immediate ignored
    doReset();
    loadAddr(16'h0300, 16'h0303, 1, 1);
    setCount(1'b0, 8'd5, 12'd300, 16'h02F0);
    walk(16'h0300, 4, 300, backs);
    check(backs == 299, "R2 register count 300", backs, 299);

    // R7/R8/R9/R10: classes at every body offset
    for (int len = 1; len <= 5; len++) begin
      for (int cls = 0; cls <= 4; cls++) begin
        for (int c = 1; c <= 3; c++) begin
          for (int off = 0; off < len; off++) begin
            s = 16'h0400; e = s + 16'(len - 1); pc = s + 16'(off);
            expExc = (cls != 0) && (len < 4);
            doReset();
            loadAddr(s, e, 1, 1);
            setCount(1'b1, 8'(c), 12'd0, s - 16'd4);
            fetchOne(s - 16'd1, 3'(cls));
            if (sExc) check(1'b0, "R7 outside body no exc", sExc, 0);
            fetchOne(pc, 3'(cls));
            check(sExc == expExc, len < 4 ? "R7 short-loop class check" : "R10 long loop allows all",
                  sExc, expExc);
            if (expExc) begin
              check(sExcPc == ((c >= 2) ? s : pc), "R8 saved PC", sExcPc, (c >= 2) ? s : pc);
              if (pc == e) begin
                check(sNext == e + 16'd1, "R9 no loop-back on exception", sNext, e + 16'd1);
                fetchOne(e, 3'd0);
                check(sNext == ((c > 1) ? s : e + 16'd1), "R9 count unchanged",
                      sNext, (c > 1) ? s : e + 16'd1);
              end
            end
          end
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule